// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable behavioural model of a parallel NOR flash that understands an Intel-style multi-cycle command set. It sits on a simple synchronous bus with a byte address, a write strobe, a read strobe, write data and registered read data. Behind the bus is a small on-chip array divided into equal, power-of-two sized sectors. Bus writes are never stored in the array directly. Each write is a step in a command sequence, and only the right sequence erases a sector or programs words.

A write-phase tracker and a latched command code decide what each bus write means. They also choose where reads come from: the array, an 8-bit status register whose bit 7 is the ready flag, or a query ROM that describes the part's geometry. A buffered-program sequence loads a word count from the full data width. The count is tested before it is decremented, so a count of N takes N+1 data writes.

Read data is registered. It appears on `bus_rdata` one clock after the edge that samples `bus_re`, taken from the source selected at that edge. The external reset is asynchronous and active low. Its release passes through a two-flop synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the block is in array-read mode, the status register is 0x00 and `bus_rdata` is 0. A status read (command 0x70) returns 0x0000 before any other operation.
- R2: In the idle phase the low 8 bits of a write are a command. 0xFF and 0x00 select array-read mode. Any code outside the set {0x00, 0x20, 0x50, 0x60, 0x70, 0x98, 0xE8, 0xFF} also returns the block to array-read mode and leaves the array unchanged.
- R3: 0x20 followed by 0xD0 sets every word of the addressed sector to all ones. The sector is the byte address shifted right by log2 of the sector size. Other sectors keep their contents. Status bit 7 becomes 1, and later reads return the status register until the next command.
- R4: 0x20 followed by anything other than 0xD0 (including 0xFF) erases nothing and returns the block to array-read mode.
- R5: 0xE8 sets status bit 7 and takes the next write's full data value as a count N. It then stores the next N+1 writes at their word addresses (byte address shifted right by log2 of the word size in bytes). A following 0xD0 ends the sequence, and reads then return the status register.
- R6: After the N+1 program data writes, a value other than 0xD0 returns the block to array-read mode. The data already written stays in the array.
- R7: 0x60 followed by 0xD0 or 0x01 sets status bit 7 and leaves the block in status-read mode. Any other second value returns it to array-read mode.
- R8: 0x50 clears the status register to 0x00 and selects array-read mode. 0x70 selects status-read mode, and the status appears in bits 7:0 of read data.
- R9: 0x98 selects query mode. A read returns ROM entry (addr[7:0] >> log2(word bytes)), zero-extended. Entries 0x10..0x12 hold 'Q','R','Y' (0x51,0x52,0x59). Entry 0x27 is log2 of the array size in bytes and entry 0x2A is log2 of the buffer size. Indexes at or past 0x31 read 0. Writes other than 0xFF keep query mode, and 0xFF leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data or command |
| bus_we | input | 1 | Write strobe, one transfer per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The sector erase is tried on every sector, and its readback at sector boundaries shows whether neighbouring sectors are touched. Two buffered programs are run, one with a small count and one with a count above 255. Each ends with its confirm aimed at an erased word, so a count that is off by one, or truncated to 8 bits, shows up as a changed word. Aborted and malformed sequences (erase aborts, a bad first byte, a bad program confirm, the lock variants) are followed straight away by array reads. These reads separate a return to array mode from a lingering status or query mode and show that nothing was erased. Query reads at a known entry, a computed entry and an entry past the end check the index shift and the zero fill.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  localparam logic [7:0] OP_RESET0  = 8'h00;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CLRSTAT = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUFPROG = 8'hE8;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_LOCKALT = 8'h01;
  localparam logic [7:0] READY_BIT  = 8'h80;

  typedef enum logic [1:0] {PH_IDLE, PH_ARG, PH_DATA, PH_CONF} phase_e;
  typedef enum logic [1:0] {SEL_ARRAY, SEL_STATUS, SEL_QUERY} rsel_e;
endpackage

// File: rtl/nor_query_rom.sv
module nor_query_rom #(
  parameter int SECTOR_BYTES = 64,
  parameter int NUM_SECTORS  = 4,
  parameter int BUF_BYTES    = 64
) (
  input  logic [7:0] idx,
  output logic [7:0] entry
);
  localparam int TOTAL_BYTES = SECTOR_BYTES * NUM_SECTORS;
  localparam logic [7:0] SIZE_LOG2 = 8'($clog2(TOTAL_BYTES));
  localparam logic [7:0] BUF_LOG2  = 8'($clog2(BUF_BYTES));
  localparam logic [15:0] NSEC_M1  = 16'(NUM_SECTORS - 1);
  localparam logic [23:0] SEC_LEN  = 24'(SECTOR_BYTES);

  always_comb begin
    case (idx)
      8'h10: entry = 8'h51;
      8'h11: entry = 8'h52;
      8'h12: entry = 8'h59;
      8'h13: entry = 8'h01;
      8'h15: entry = 8'h31;
      8'h1B: entry = 8'h45;
      8'h1C: entry = 8'h55;
      8'h1F: entry = 8'h07;
      8'h20: entry = 8'h07;
      8'h21: entry = 8'h0A;
      8'h23: entry = 8'h04;
      8'h24: entry = 8'h04;
      8'h25: entry = 8'h04;
      8'h27: entry = SIZE_LOG2;
      8'h28: entry = 8'h02;
      8'h2A: entry = BUF_LOG2;
      8'h2C: entry = 8'h01;
      8'h2D: entry = NSEC_M1[7:0];
      8'h2E: entry = NSEC_M1[15:8];
      8'h2F: entry = SEC_LEN[15:8];
      8'h30: entry = SEC_LEN[23:16];
      default: entry = 8'h00;
    endcase
  end
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int DATA_W      = 16,
  parameter int WORDS       = 128,
  parameter int WORDS_PER_S = 32,
  parameter int SEC_W       = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_en,
  input  logic [$clog2(WORDS)-1:0] word_idx,
  input  logic [DATA_W-1:0]        prog_data,
  input  logic                     erase_en,
  input  logic [SEC_W-1:0]         erase_sec,
  output logic [DATA_W-1:0]        rd_data
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (erase_en) begin
      for (int w = 0; w < WORDS; w++) begin
        if ((w / WORDS_PER_S) == int'(erase_sec)) mem[w] <= '1;
      end
    end else if (prog_en) begin
      mem[word_idx] <= prog_data;
    end
  end

  assign rd_data = mem[word_idx];

  // R3 / R5: erase and program never requested in the same cycle
  a_r3_erase_prog_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_en, prog_en}));
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_flash_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output rsel_e             rd_sel,
  output logic [7:0]        status,
  output logic              prog_en,
  output logic              erase_en
);
  localparam int CNT_W = DATA_W;

  phase_e             phase_q, phase_d;
  logic [7:0]         cmd_q, cmd_d;
  logic [7:0]         stat_q, stat_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [7:0]         op;

  assign op = wdata[7:0];

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = cmd_q;
    stat_d   = stat_q;
    cnt_d    = cnt_q;
    prog_en  = 1'b0;
    erase_en = 1'b0;
    if (wr) begin
      case (phase_q)
        PH_IDLE: begin
          case (op)
            OP_ERASE, OP_LOCK, OP_QUERY: begin
              cmd_d   = op;
              phase_d = PH_ARG;
            end
            OP_BUFPROG: begin
              cmd_d   = op;
              phase_d = PH_ARG;
              stat_d  = stat_q | READY_BIT;
            end
            OP_CLRSTAT: begin
              stat_d = 8'h00;
              cmd_d  = OP_RESET0;
            end
            OP_STATUS: cmd_d = op;
            default:   cmd_d = OP_RESET0;
          endcase
        end
        PH_ARG: begin
          phase_d = PH_IDLE;
          case (cmd_q)
            OP_ERASE: begin
              if (op == OP_CONFIRM) begin
                erase_en = 1'b1;
                stat_d   = stat_q | READY_BIT;
              end else begin
                cmd_d = OP_RESET0;
              end
            end
            OP_BUFPROG: begin
              cnt_d   = wdata;
              phase_d = PH_DATA;
            end
            OP_LOCK: begin
              if (op == OP_CONFIRM || op == OP_LOCKALT) stat_d = stat_q | READY_BIT;
              else cmd_d = OP_RESET0;
            end
            OP_QUERY: begin
              if (op == OP_ARRAY) cmd_d = OP_RESET0;
              else phase_d = PH_ARG;
            end
            default: cmd_d = OP_RESET0;
          endcase
        end
        PH_DATA: begin
          prog_en = 1'b1;
          stat_d  = stat_q | READY_BIT;
          if (cnt_q == '0) phase_d = PH_CONF;
          cnt_d = cnt_q - 1'b1;
        end
        default: begin
          phase_d = PH_IDLE;
          if (op == OP_CONFIRM) stat_d = stat_q | READY_BIT;
          else cmd_d = OP_RESET0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cmd_q   <= OP_RESET0;
      stat_q  <= 8'h00;
      cnt_q   <= '0;
    end else if (wr) begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      stat_q  <= stat_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    case (cmd_q)
      OP_RESET0: rd_sel = SEL_ARRAY;
      OP_QUERY:  rd_sel = SEL_QUERY;
      default:   rd_sel = SEL_STATUS;
    endcase
  end
  assign status = stat_q;

  // R5: each data write in the program phase lowers the count by one
  a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && phase_q == PH_DATA && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R6: the confirm phase only exists inside a buffered program
  a_r6_conf_only_program: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONF) |-> (cmd_q == OP_BUFPROG));
  // R8: a clear command in the idle phase empties the status register
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && phase_q == PH_IDLE && op == OP_CLRSTAT) |=> (stat_q == 8'h00));
  // R3: a confirmed erase leaves the ready flag set
  a_r3_erase_ready: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> stat_q[7]);
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_flash_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SECTOR_BYTES = 64,
  parameter int NUM_SECTORS  = 4,
  parameter int BUF_BYTES    = 64,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES * NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int WORD_BYTES  = DATA_W / 8;
  localparam int BYTE_SH     = $clog2(WORD_BYTES);
  localparam int SEC_SH      = $clog2(SECTOR_BYTES);
  localparam int SEC_W       = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
  localparam int WORDS       = SECTOR_BYTES * NUM_SECTORS / WORD_BYTES;
  localparam int WORDS_PER_S = SECTOR_BYTES / WORD_BYTES;
  localparam logic [7:0] QLEN = 8'h31;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rsel_e             rd_sel;
  logic [7:0]        status;
  logic              prog_en, erase_en;
  logic [DATA_W-1:0] arr_data;
  logic [7:0]        q_idx, q_entry;
  logic [SEC_W-1:0]  sec;
  logic [DATA_W-1:0] rd_next;

  assign q_idx = bus_addr[7:0] >> BYTE_SH;
  assign sec   = SEC_W'(bus_addr >> SEC_SH);

  nor_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .wr(bus_we), .wdata(bus_wdata),
    .rd_sel(rd_sel), .status(status), .prog_en(prog_en), .erase_en(erase_en)
  );

  nor_array #(.DATA_W(DATA_W), .WORDS(WORDS), .WORDS_PER_S(WORDS_PER_S), .SEC_W(SEC_W)) u_arr (
    .clk(clk), .rst_n(rst_sync_n), .prog_en(prog_en),
    .word_idx(bus_addr[ADDR_W-1:BYTE_SH]), .prog_data(bus_wdata),
    .erase_en(erase_en), .erase_sec(sec), .rd_data(arr_data)
  );

  nor_query_rom #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS), .BUF_BYTES(BUF_BYTES)) u_rom (
    .idx(q_idx), .entry(q_entry)
  );

  always_comb begin
    case (rd_sel)
      SEL_STATUS: rd_next = DATA_W'(status);
      SEL_QUERY:  rd_next = DATA_W'(q_entry);
      default:    rd_next = arr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

  // R9: query reads beyond the ROM end return zero
  a_r9_query_tail_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_re && rd_sel == SEL_QUERY && q_idx >= QLEN) |=> (bus_rdata == '0));
  // R8: status-mode reads carry nothing above the 8-bit status
  a_r8_status_width: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_re && rd_sel == SEL_STATUS) |=> (bus_rdata[DATA_W-1:8] == '0));
endmodule

// File: tb/sim_nor_cmd_flash.sv
`timescale 1ns/1ps
module sim_nor_cmd_flash;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [15:0] bus_rdata;
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  nor_cmd_flash u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    check("R1 rdata after reset", bus_rdata, 16'h0000);
    wr(8'h00, 16'h0070);
    rd_chk("R1 status after reset", 8'h00, 16'h0000);
  endtask

  task automatic t_erase_all;
    for (int s = 0; s < 4; s++) begin
      wr(8'(s * 64), 16'h0020);
      wr(8'(s * 64), 16'h00D0);
      rd_chk("R3 ready after erase", 8'(s * 64), 16'h0080);
      wr(8'(s * 64), 16'h00FF);
      rd_chk("R3 sector first word", 8'(s * 64), 16'hFFFF);
      rd_chk("R3 sector last word", 8'(s * 64 + 62), 16'hFFFF);
    end
  endtask

  task automatic t_program;
    wr(8'h00, 16'h0050);
    wr(8'h40, 16'h00E8);
    wr(8'h40, 16'h0002);
    wr(8'h40, 16'hA001);
    wr(8'h42, 16'hA002);
    wr(8'h44, 16'hA003);
    wr(8'h46, 16'h00D0);
    rd_chk("R5 ready after program", 8'h46, 16'h0080);
    wr(8'h00, 16'h00FF);
    rd_chk("R5 word0", 8'h40, 16'hA001);
    rd_chk("R5 word1", 8'h42, 16'hA002);
    rd_chk("R5 word2", 8'h44, 16'hA003);
    rd_chk("R5 confirm not stored", 8'h46, 16'hFFFF);
  endtask

  task automatic t_erase_abort;
    wr(8'h40, 16'h0020);
    wr(8'h40, 16'h00FF);
    rd_chk("R4 abort by FF keeps data", 8'h40, 16'hA001);
    wr(8'h40, 16'h0020);
    wr(8'h40, 16'h0055);
    rd_chk("R4 bad second cycle keeps data", 8'h42, 16'hA002);
  endtask

  task automatic t_bad_cmd;
    wr(8'h44, 16'h0033);
    rd_chk("R2 unknown op reads array", 8'h44, 16'hA003);
    wr(8'h44, 16'h0070);
    wr(8'h44, 16'h0000);
    rd_chk("R2 op 00 reads array", 8'h44, 16'hA003);
  endtask

  task automatic t_prog_bad_confirm;
    wr(8'h46, 16'h00E8);
    wr(8'h46, 16'h0000);
    wr(8'h46, 16'h1234);
    wr(8'h46, 16'h0077);
    rd_chk("R6 bad confirm back to array", 8'h46, 16'h1234);
  endtask

  task automatic t_lock;
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h00D0);
    rd_chk("R7 lock D0 ready", 8'h00, 16'h0080);
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h0001);
    rd_chk("R7 lock 01 ready", 8'h00, 16'h0080);
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h00FF);
    rd_chk("R7 lock FF array", 8'h40, 16'hA001);
    wr(8'h00, 16'h0060);
    wr(8'h00, 16'h0042);
    rd_chk("R7 lock other array", 8'h42, 16'hA002);
  endtask

  task automatic t_clear;
    wr(8'h00, 16'h0070);
    rd_chk("R8 status before clear", 8'h00, 16'h0080);
    wr(8'h00, 16'h0050);
    rd_chk("R8 clear returns array", 8'h40, 16'hA001);
    wr(8'h00, 16'h0070);
    rd_chk("R8 status cleared", 8'h00, 16'h0000);
  endtask

  task automatic t_query;
    wr(8'h00, 16'h0098);
    rd_chk("R9 Q", 8'h20, 16'h0051);
    rd_chk("R9 R", 8'h22, 16'h0052);
    rd_chk("R9 Y", 8'h24, 16'h0059);
    rd_chk("R9 size log2", 8'h4E, 16'h0008);
    rd_chk("R9 buffer log2", 8'h54, 16'h0006);
    rd_chk("R9 past end", 8'hFE, 16'h0000);
    wr(8'h00, 16'h0012);
    rd_chk("R9 stays in query", 8'h20, 16'h0051);
    wr(8'h00, 16'h00FF);
    rd_chk("R9 FF leaves query", 8'h40, 16'hA001);
  endtask

  task automatic t_big_program;
    wr(8'h00, 16'h0050);
    wr(8'hC0, 16'h00E8);
    wr(8'hC0, 16'h0100);
    for (int i = 0; i < 257; i++) wr(8'(8'hC0 + (i % 32) * 2), 16'(i));
    wr(8'h3E, 16'h00D0);
    rd_chk("R5 big count ready", 8'h3E, 16'h0080);
    wr(8'h00, 16'h00FF);
    rd_chk("R5 big count confirm not stored", 8'h3E, 16'hFFFF);
    rd_chk("R5 big count last wrap", 8'hC0, 16'h0100);
    rd_chk("R5 big count word1", 8'hC2, 16'h00E1);
    rd_chk("R5 big count word31", 8'hFE, 16'h00FF);
    wr(8'h80, 16'h0020);
    wr(8'h80, 16'h00D0);
    wr(8'h00, 16'h00FF);
    rd_chk("R3 neighbour above kept", 8'hC2, 16'h00E1);
    rd_chk("R3 neighbour below kept", 8'h40, 16'hA001);
  endtask

  initial begin
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_erase_all();
    t_program();
    t_erase_abort();
    t_bad_cmd();
    t_prog_bad_confirm();
    t_lock();
    t_clear();
    t_query();
    t_big_program();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule